// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial PCM stream into parallel samples. It runs on the bit clock and samples a frame clock and one data line on every rising edge. It places each left and right word in a 24-bit two's-complement register and raises a one-cycle strobe when a complete left/right pair is ready. Words shorter than 24 bits are sign-extended.

A static 3-bit format code selects how the words sit in the frame: right-aligned to the end of a half-frame, left-aligned to its start, or left-aligned with a one-bit delay. The same code also selects a word length of 16, 20 or 24 bits. A static polarity input decides which frame-clock level marks the left half. The format code and polarity are changed only while reset is held. The inputs are assumed to be already synchronous to the bit clock.

Top module: `pcm_serial_rx`

## Requirements
- R1: The format code selects framing and word length. Code 0 is right-aligned 16-bit, 1 is right-aligned 20-bit, 2 is right-aligned 24-bit, 3 is left-aligned 24-bit, 4 is delayed 16-bit, 5 is delayed 24-bit, 6 is delayed 20-bit, and 7 is left-aligned 20-bit.
- R2: In right-aligned framing, the word is the last N bits sampled before the frame-clock change. Any earlier bits in that half-frame are discarded.
- R3: In left-aligned framing, the word is the first N bits of the half-frame. The first bit is the one sampled at the first rising edge that sees the new frame-clock level. Bits arrive MSB first, and trailing bits are ignored.
- R4: In delayed framing, the word starts one bit-clock cycle after the left-aligned position. The bit at the frame edge is ignored.
- R5: With polarity 0, a high frame clock marks the left half. With polarity 1, a low frame clock marks the left half. Left always precedes right within a frame.
- R6: Words shorter than 24 bits appear on the outputs sign-extended from bit N-1.
- R7: The valid output is high for exactly one cycle per frame, after the right word is captured. In that cycle it presents the right word together with the left word of the same frame.
- R8: Synchronous reset clears both sample outputs and valid. After reset, no capture happens until the first frame-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and frame clock sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Static format code (R1) |
| lr_pol | input | 1 | Static frame-clock polarity select |
| lrck | input | 1 | Frame (left/right) clock |
| sdata | input | 1 | Serial data line, MSB first |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions assume that each half-frame lasts at least N+2 bit-clock cycles, so a left-aligned or delayed capture finishes before the next frame edge. They also assume that the format code and polarity are stable outside reset. The stimulus meets both assumptions: every half-frame is 32 bit-clocks long, and the bench changes the format or polarity only while reset is held. Filler bits are random, so discarded bit positions cannot mask an error. The line idles at the right-half level before the first frame. Under right-aligned framing, the first frame edge therefore yields an all-zero pair, which the bench expects.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic [1:0] {FR_RIGHT = 2'd0, FR_LEFT = 2'd1, FR_DELAY = 2'd2} framing_e;
endpackage

// File: rtl/pcm_fmt_decode.sv
module pcm_fmt_decode
  import pcm_rx_pkg::*;
#(
  parameter int NW = 5
) (
  input  logic [2:0]    fmt,
  output framing_e      framing,
  output logic [NW-1:0] nbits
);
  always_comb begin
    framing = FR_RIGHT;
    nbits   = NW'(16);
    unique case (fmt)
      3'd0: begin framing = FR_RIGHT; nbits = NW'(16); end
      3'd1: begin framing = FR_RIGHT; nbits = NW'(20); end
      3'd2: begin framing = FR_RIGHT; nbits = NW'(24); end
      3'd3: begin framing = FR_LEFT;  nbits = NW'(24); end
      3'd4: begin framing = FR_DELAY; nbits = NW'(16); end
      3'd5: begin framing = FR_DELAY; nbits = NW'(24); end
      3'd6: begin framing = FR_DELAY; nbits = NW'(20); end
      default: begin framing = FR_LEFT; nbits = NW'(20); end
    endcase
  end
endmodule

// File: rtl/pcm_bit_shifter.sv
module pcm_bit_shifter
  import pcm_rx_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = 6,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lrck,
  input  logic          sdata,
  input  logic          lr_pol,
  input  framing_e      framing,
  input  logic [NW-1:0] nbits,
  output logic          cap_o,
  output logic          cap_left_o,
  output logic [W-1:0]  word_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [W-1:0]  sr;
  logic          lrck_q;
  logic          armed;
  logic [CW-1:0] cnt;
  logic          frame_edge;
  logic          hit;
  logic [CW-1:0] target;

  assign frame_edge = armed && (lrck != lrck_q);
  assign target     = CW'(nbits) + ((framing == FR_DELAY) ? CW'(1) : CW'(0));
  assign hit        = (framing == FR_RIGHT) ? frame_edge : (!frame_edge && cnt == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      lrck_q     <= 1'b0;
      armed      <= 1'b0;
      cnt        <= CNT_MAX;
      cap_o      <= 1'b0;
      cap_left_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sr     <= {sr[W-2:0], sdata};
      lrck_q <= lrck;
      armed  <= 1'b1;
      if (frame_edge)          cnt <= CW'(1);
      else if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
      cap_o <= hit;
      if (hit) begin
        cap_left_o <= (lrck_q != lr_pol);
        word_o     <= sr;
      end
    end
  end

  // R8: nothing is captured before the first frame-clock change after reset
  a_r8_no_capture_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !cap_o);
endmodule

// File: rtl/pcm_word_out.sv
module pcm_word_out #(
  parameter int W  = 24,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          cap_left,
  input  logic [W-1:0]  word,
  input  logic [NW-1:0] nbits,
  output logic [W-1:0]  left_o,
  output logic [W-1:0]  right_o,
  output logic          valid_o
);
  logic [NW-1:0]       sh;
  logic signed [W-1:0] shifted;
  logic signed [W-1:0] ext;
  logic [W-1:0]        left_hold;

  always_comb begin
    sh      = NW'(W) - nbits;
    shifted = $signed(word << sh);
    ext     = shifted >>> sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap && cap_left) left_hold <= ext;
      if (cap && !cap_left) begin
        left_o  <= left_hold;
        right_o <= ext;
        valid_o <= 1'b1;
      end
    end
  end

  logic signed [W-1:0] lchk, rchk;
  assign lchk = $signed(left_o) >>> (nbits - NW'(1));
  assign rchk = $signed(right_o) >>> (nbits - NW'(1));

  a_r6_left_sign_ext: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (lchk == '0 || lchk == '1));
  a_r6_right_sign_ext: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rchk == '0 || rchk == '1));
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   fmt,
  input  logic         lr_pol,
  input  logic         lrck,
  input  logic         sdata,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam int NW = $clog2(W + 1);

  framing_e      framing;
  logic [NW-1:0] nbits;
  logic          cap, cap_left;
  logic [W-1:0]  word;

  pcm_fmt_decode #(.NW(NW)) u_dec (
    .fmt(fmt), .framing(framing), .nbits(nbits)
  );

  pcm_bit_shifter #(.W(W), .CW(CW), .NW(NW)) u_shift (
    .clk(clk), .rst(rst), .lrck(lrck), .sdata(sdata), .lr_pol(lr_pol),
    .framing(framing), .nbits(nbits),
    .cap_o(cap), .cap_left_o(cap_left), .word_o(word)
  );

  pcm_word_out #(.W(W), .NW(NW)) u_out (
    .clk(clk), .rst(rst), .cap(cap), .cap_left(cap_left), .word(word),
    .nbits(nbits), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // R1: every code decodes to one of the three supported word lengths
  a_r1_width_legal: assert property (@(posedge clk) disable iff (rst)
    (nbits == NW'(16) || nbits == NW'(20) || nbits == NW'(24)));
  // R7: a right-word capture is followed by the pair strobe
  a_r7_pair_after_right: assert property (@(posedge clk) disable iff (rst)
    (cap && !cap_left) |=> valid_o);
endmodule

// File: tb/pcm_serial_rx_test.sv
`timescale 1ns/1ps
module pcm_serial_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] fmt = 3'd0;
  logic lr_pol = 1'b0;
  logic lrck = 1'b0;
  logic sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o;

  pcm_serial_rx uut (
    .clk(clk), .rst(rst), .fmt(fmt), .lr_pol(lr_pol), .lrck(lrck),
    .sdata(sdata), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_l [0:63];
  logic [23:0] exp_r [0:63];
  int wr_i = 0;
  int rd_i = 0;
  int cur_n = 16;
  int cur_fr = 0;
  logic prev_valid = 1'b0;

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(logic [2:0] f);
    case (f)
      3'd0, 3'd4: return 16;
      3'd1, 3'd6, 3'd7: return 20;
      default: return 24;
    endcase
  endfunction

  // 0 = right-aligned, 1 = left-aligned, 2 = delayed by one bit
  function automatic int framing_of(logic [2:0] f);
    case (f)
      3'd0, 3'd1, 3'd2: return 0;
      3'd3, 3'd7: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [23:0] sext(logic [23:0] v, int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic string tag_of();
    string t;
    t = (cur_fr == 0) ? "R1 R2" : (cur_fr == 1) ? "R1 R3" : "R1 R4";
    if (lr_pol) t = {t, " R5"};
    return t;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o && prev_valid) check(1'b0, "R7 strobe longer than one cycle", 24'd1, 24'd0);
      if (valid_o) begin
        if (rd_i >= wr_i) begin
          check(1'b0, "R7 unexpected strobe", 24'(rd_i), 24'(wr_i));
        end else begin
          logic [23:0] m;
          m = (24'h1 << cur_n) - 24'h1;
          check((left_o & m) == (exp_l[rd_i] & m), {tag_of(), " left word"}, left_o, exp_l[rd_i]);
          check((right_o & m) == (exp_r[rd_i] & m), {tag_of(), " right word"}, right_o, exp_r[rd_i]);
          check(left_o == exp_l[rd_i] && right_o == exp_r[rd_i], "R6 sign extension",
                (left_o == exp_l[rd_i]) ? right_o : left_o,
                (left_o == exp_l[rd_i]) ? exp_r[rd_i] : exp_l[rd_i]);
          rd_i++;
        end
      end
    end
    prev_valid = valid_o;
  end

  task automatic push(logic [23:0] l, logic [23:0] r);
    exp_l[wr_i] = sext(l, cur_n);
    exp_r[wr_i] = sext(r, cur_n);
    wr_i++;
  endtask

  task automatic send_half(logic level, logic [23:0] w);
    for (int s = 0; s < 32; s++) begin
      logic b;
      b = 1'($urandom);
      if (cur_fr == 0 && s >= 32 - cur_n) b = w[cur_n - 1 - (s - (32 - cur_n))];
      if (cur_fr == 1 && s < cur_n) b = w[cur_n - 1 - s];
      if (cur_fr == 2 && s >= 1 && s <= cur_n) b = w[cur_n - s];
      @(negedge clk);
      lrck  <= level;
      sdata <= b;
    end
  endtask

  task automatic run(logic [2:0] f, logic pol, int frames);
    @(negedge clk);
    rst <= 1'b1;
    fmt <= f;
    lr_pol <= pol;
    lrck <= pol;
    sdata <= 1'b0;
    repeat (2) @(negedge clk);
    wr_i = 0;
    rd_i = 0;
    cur_n = width_of(f);
    cur_fr = framing_of(f);
    rst <= 1'b0;
    repeat (3) @(negedge clk);
    if (cur_fr == 0) push(24'h0, 24'h0);
    for (int k = 0; k < frames; k++) begin
      logic [23:0] l, r, m;
      m = (24'h1 << cur_n) - 24'h1;
      l = 24'($urandom) & m;
      r = 24'($urandom) & m;
      if (k == 0) begin l = 24'h1 << (cur_n - 1); r = m >> 1; end
      if (k == 1) begin l = m; r = 24'h0; end
      push(l, r);
      send_half(~pol, l);
      send_half(pol, r);
    end
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      lrck  <= ~pol;
      sdata <= 1'b0;
    end
    repeat (4) @(negedge clk);
    check(rd_i == wr_i, "R7 one strobe per frame", 24'(rd_i), 24'(wr_i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(left_o == 24'h0, "R8 left after reset", left_o, 24'h0);
    check(right_o == 24'h0, "R8 right after reset", right_o, 24'h0);
    check(valid_o == 1'b0, "R8 valid after reset", 24'(valid_o), 24'h0);
    void'($urandom(32'd2024));
    for (int f = 0; f < 8; f++) begin
      run(3'(f), 1'b0, 5);
      run(3'(f), 1'b1, 4);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'd1, 24'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule